// File: doc/BRIEF.md
# EPROM Identity Check Sequencer

This block runs the identity step that a device programmer performs before it writes to a UV-erasable or one-time-programmable memory. A single start pulse launches a fixed sequence. The block raises a request flag that asks the board to drive the high-voltage identification level onto the A9 address pin, then waits a programmable settle time. It then selects the part with chip and output enable both low and reads two identity bytes. The lowest address bit chooses between the two bytes, and every other address line is held low throughout.

Each byte is sampled a programmable number of cycles after the address changes. After the second byte the enables are released first, and only then is the high-voltage request withdrawn. The two captured bytes are compared against the expected manufacturer and device codes, which are parameters and default to 20h and 3Dh. The result is shown on a match flag or a mismatch flag, and a one-cycle done pulse closes the sequence. The 12 V level itself is produced outside this block.

Top module: `sig_ident_seq`

## Requirements
- R1: After a synchronous active-low reset: `hv_req`=0, `ce_n`=1, `oe_n`=1, `addr`=0, `busy`=0, `done`=0, `match`=0, `mismatch`=0.
- R2: While a sequence runs, every address bit other than bit 0 stays 0, and `addr[0]` is 1 only while the enables are active.
- R3: `hv_req` rises on the cycle after an accepted `start`. It then stays high with the enables inactive for exactly `settle_len`+1 cycles before `ce_n` and `oe_n` fall.
- R4: The enables stay low for two access phases of `access_len`+1 cycles each. In the first phase `addr[0]`=0 and in the second `addr[0]`=1, and `rd_data` is sampled on the last cycle of each phase.
- R5: The byte read with `addr[0]`=0 appears on `mfr_q`, and the byte read with `addr[0]`=1 appears on `dev_q`.
- R6: After the second phase the enables go high for exactly one cycle while `hv_req` is still high. `hv_req` then falls.
- R7: `done` is high for exactly one cycle, the same cycle in which `hv_req` first falls. `busy` is low from the next cycle.
- R8: From the `done` cycle until the next accepted start, `match`=1 only when `mfr_q` equals EXP_MFR (default 20h) and `dev_q` equals EXP_DEV (default 3Dh). Otherwise `mismatch`=1. The two flags are never high together.
- R9: A `start` pulse that arrives while `busy` is high is ignored. The running sequence keeps its timing, and no second sequence follows.
- R10: `ce_n` and `oe_n` are always equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle launch pulse |
| settle_len | input | CNT_W | Settle cycles after the high-voltage request, minus one |
| access_len | input | CNT_W | Access cycles per byte after an address change, minus one |
| rd_data | input | 8 | Data bus from the memory |
| hv_req | output | 1 | Request for the identification voltage on A9 |
| addr | output | ADDR_W | Address to the memory; only bit 0 toggles |
| ce_n | output | 1 | Chip enable, active low |
| oe_n | output | 1 | Output enable, active low |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| mfr_q | output | 8 | Captured manufacturer byte |
| dev_q | output | 8 | Captured device byte |
| match | output | 1 | Both bytes equal the expected codes |
| mismatch | output | 1 | At least one byte differs |

## Verification
The hardest case to reach is sampling at the wrong moment, one cycle early or late in an access phase. A memory that answers instantly hides this. The bench's memory model therefore drives a wrong value until the enables have been low and `addr[0]` unchanged for `access_len` cycles, so an early sample captures the wrong byte. A start pulse in the middle of a sequence is injected while the first byte is being read, to check that the sequence keeps its timing.

// File: rtl/sig_pkg.sv
// Package: shared state encoding for the identity check sequencer.
// Assumes: no other package defines these names.
package sig_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_ACC0,
        ST_ACC1,
        ST_REL,
        ST_FIN
    } sig_state_t;
endpackage

// File: rtl/sig_timer.sv
// Module: loadable down-counter used for the settle and access delays.
// Assumes: load has priority over counting; expired is high when the count is zero.
module sig_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    // Load a new delay or count down toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/sig_compare.sv
// Module: compares the captured identity bytes with the expected codes.
// Assumes: the bytes are stable while valid is high.
module sig_compare #(
    parameter logic [7:0] EXP_MFR = 8'h20,
    parameter logic [7:0] EXP_DEV = 8'h3D
) (
    input  logic       valid,
    input  logic [7:0] mfr,
    input  logic [7:0] dev,
    output logic       match,
    output logic       mismatch
);
    logic equal;

    // Both bytes must agree with the expected codes.
    always_comb begin
        equal    = (mfr == EXP_MFR) && (dev == EXP_DEV);
        match    = valid && equal;
        mismatch = valid && !equal;
    end
endmodule

// File: rtl/sig_ident_seq.sv
// Module: identity check sequencer (top).
// Requests the A9 identification voltage, waits for it to settle, reads two
// bytes with A0 = 0 and A0 = 1, releases the enables, then drops the request.
// Assumes: the board applies the voltage while hv_req is high, and rd_data is
// valid access_len cycles after an address change.
module sig_ident_seq
    import sig_pkg::*;
#(
    parameter int         CNT_W   = 8,
    parameter int         ADDR_W  = 16,
    parameter logic [7:0] EXP_MFR = 8'h20,
    parameter logic [7:0] EXP_DEV = 8'h3D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  settle_len,
    input  logic [CNT_W-1:0]  access_len,
    input  logic [7:0]        rd_data,
    output logic              hv_req,
    output logic [ADDR_W-1:0] addr,
    output logic              ce_n,
    output logic              oe_n,
    output logic              busy,
    output logic              done,
    output logic [7:0]        mfr_q,
    output logic [7:0]        dev_q,
    output logic              match,
    output logic              mismatch
);
    localparam int HI_W = ADDR_W - 1;

    sig_state_t       state, state_nx;
    logic             tmr_load, tmr_done;
    logic [CNT_W-1:0] tmr_val;
    logic             res_valid;

    sig_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    // Next-state and delay-load decode.
    always_comb begin
        state_nx = state;
        tmr_load = 1'b0;
        tmr_val  = access_len;
        unique case (state)
            ST_IDLE:   if (start) begin
                           state_nx = ST_SETTLE;
                           tmr_load = 1'b1;
                           tmr_val  = settle_len;
                       end
            ST_SETTLE: if (tmr_done) begin
                           state_nx = ST_ACC0;
                           tmr_load = 1'b1;
                       end
            ST_ACC0:   if (tmr_done) begin
                           state_nx = ST_ACC1;
                           tmr_load = 1'b1;
                       end
            ST_ACC1:   if (tmr_done) state_nx = ST_REL;
            ST_REL:    state_nx = ST_FIN;
            ST_FIN:    state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Capture each byte on the last cycle of its access phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mfr_q <= '0;
            dev_q <= '0;
        end else begin
            if (state == ST_ACC0 && tmr_done) mfr_q <= rd_data;
            if (state == ST_ACC1 && tmr_done) dev_q <= rd_data;
        end
    end

    // Result qualifier: set entering the end cycle, cleared on a new start.
    always_ff @(posedge clk) begin
        if (!rst_n)                         res_valid <= 1'b0;
        else if (state == ST_IDLE && start) res_valid <= 1'b0;
        else if (state == ST_REL)           res_valid <= 1'b1;
    end

    sig_compare #(.EXP_MFR(EXP_MFR), .EXP_DEV(EXP_DEV)) u_cmp (
        .valid    (res_valid),
        .mfr      (mfr_q),
        .dev      (dev_q),
        .match    (match),
        .mismatch (mismatch)
    );

    // Pin decode from the current state.
    always_comb begin
        hv_req = (state == ST_SETTLE) || (state == ST_ACC0) ||
                 (state == ST_ACC1)   || (state == ST_REL);
        ce_n   = !((state == ST_ACC0) || (state == ST_ACC1));
        oe_n   = ce_n;
        addr   = {{HI_W{1'b0}}, (state == ST_ACC1)};
        busy   = (state != ST_IDLE);
        done   = (state == ST_FIN);
    end

    // R3: the enables never fall unless the voltage request was already up.
    a_r3_hv_before_select: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ce_n) |-> $past(hv_req));

    // R6: the request drops only after the enables were inactive.
    a_r6_release_first: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hv_req) |-> ($past(ce_n) && $past(oe_n)));

    // R7: done lasts a single cycle.
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: exactly one result flag is shown at the end of a sequence.
    a_r8_one_result: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $onehot({match, mismatch}));

    // R4: the first byte holds until its phase timer expires.
    a_r4_hold_until_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACC0 && !tmr_done) |=> $stable(mfr_q));

    // R2: A0 is only raised while the part is selected.
    a_r2_a0_while_selected: assert property (@(posedge clk) disable iff (!rst_n)
        addr[0] |-> !ce_n);
endmodule

// File: tb/sig_ident_seq_test.sv
module sig_ident_seq_test;
    localparam int CNT_W  = 8;
    localparam int ADDR_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [CNT_W-1:0]  settle_len = '0;
    logic [CNT_W-1:0]  access_len = '0;
    logic [7:0]        rd_data;
    logic              hv_req, ce_n, oe_n, busy, done, match, mismatch;
    logic [ADDR_W-1:0] addr;
    logic [7:0]        mfr_q, dev_q;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    sig_ident_seq #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .settle_len(settle_len), .access_len(access_len), .rd_data(rd_data),
        .hv_req(hv_req), .addr(addr), .ce_n(ce_n), .oe_n(oe_n),
        .busy(busy), .done(done), .mfr_q(mfr_q), .dev_q(dev_q),
        .match(match), .mismatch(mismatch)
    );

    always #5 clk = ~clk;

    // Memory model: identity bytes valid only after access_len stable cycles.
    logic [7:0] rom_mfr = 8'h20, rom_dev = 8'h3D;
    int   age = 0;
    logic last_a0 = 1'b0;
    always @(posedge clk) begin
        if (ce_n)                 age <= 0;
        else if (addr[0] != last_a0) age <= 1;
        else                      age <= age + 1;
        last_a0 <= addr[0];
    end
    always_comb begin
        if (!ce_n && !oe_n && hv_req && age >= int'(access_len))
            rd_data = addr[0] ? rom_dev : rom_mfr;
        else
            rd_data = 8'hFF;
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // settle, access, memory mfr byte, memory dev byte
    localparam logic [31:0] VEC [0:4] = '{
        {8'd0, 8'd0, 8'h20, 8'h3D},
        {8'd3, 8'd2, 8'h20, 8'h3E},
        {8'd7, 8'd5, 8'h21, 8'h3D},
        {8'd1, 8'd9, 8'h3D, 8'h20},
        {8'd12, 8'd4, 8'h20, 8'h3D}
    };

    task automatic run_seq(input int s, input int a, input logic [7:0] m,
                           input logic [7:0] d, input bit poke);
        int n_set = 0, n_a0 = 0, n_a1 = 0, n_rel = 0, bad_addr = 0, bad_en = 0;
        int n = 0;
        bit seen_ce = 0, poked = 0, ok_done = 0, exp_match;
        settle_len = CNT_W'(s);
        access_len = CNT_W'(a);
        rom_mfr = m;
        rom_dev = d;
        exp_match = (m == 8'h20) && (d == 8'h3D);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        check(hv_req == 1'b1, "R3 request rises", hv_req, 1);
        while (n < 2000) begin
            if (start) start = 1'b0;
            if (addr[ADDR_W-1:1] != '0) bad_addr++;
            if (addr[0] && ce_n) bad_addr++;
            if (ce_n != oe_n) bad_en++;
            if (hv_req && ce_n && !seen_ce) n_set++;
            if (!ce_n) begin
                seen_ce = 1;
                if (addr[0]) n_a1++; else n_a0++;
            end
            if (seen_ce && ce_n && hv_req) n_rel++;
            if (poke && n_a0 == 1 && !poked) begin
                start = 1'b1;   // R9: start while busy
                poked = 1;
            end
            if (done) begin
                ok_done = 1;
                check(hv_req == 1'b0, "R7 request low at done", hv_req, 0);
                check(match == exp_match && mismatch == !exp_match, "R8 result",
                      {match, mismatch}, {exp_match, !exp_match});
                break;
            end
            n++;
            @(negedge clk);
        end
        check(ok_done, "R7 done seen", ok_done, 1);
        check(n_set == s + 1, "R3 settle cycles", n_set, s + 1);
        check(n_a0 == a + 1, "R4 first phase", n_a0, a + 1);
        check(n_a1 == a + 1, "R4 second phase", n_a1, a + 1);
        check(n_rel == 1, "R6 release cycle", n_rel, 1);
        check(bad_addr == 0, "R2 address lines", bad_addr, 0);
        check(bad_en == 0, "R10 enables equal", bad_en, 0);
        check(mfr_q == m, "R5 mfr byte", mfr_q, m);
        check(dev_q == d, "R5 dev byte", dev_q, d);
        @(negedge clk);
        check(done == 1'b0 && busy == 1'b0, "R7 single pulse", {done, busy}, 0);
        check(match == exp_match, "R8 result held", match, exp_match);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(hv_req == 0 && ce_n == 1 && oe_n == 1 && addr == '0 && busy == 0 &&
              done == 0 && match == 0 && mismatch == 0, "R1 reset state",
              {hv_req, ce_n, oe_n, busy, done, match, mismatch}, 7'b0110000);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 0 && hv_req == 0, "R1 idle after reset", {busy, hv_req}, 0);

        for (int i = 0; i < 5; i++)
            run_seq(int'(VEC[i][31:24]), int'(VEC[i][23:16]), VEC[i][15:8], VEC[i][7:0], 1'b0);

        // R9: start during the first access phase is ignored.
        run_seq(4, 3, 8'h20, 8'h3D, 1'b1);
        begin
            int extra = 0;
            for (int k = 0; k < 30; k++) begin
                @(negedge clk);
                if (hv_req || busy) extra++;
            end
            check(extra == 0, "R9 no second sequence", extra, 0);
        end

        // R8: a new start clears the previous result.
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        check(match == 0 && mismatch == 0, "R8 cleared on start", {match, mismatch}, 0);
        wait (done == 1'b1);
        @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule